// File: doc/BRIEF.md
# Flag-Setting ALU with Operand Shifter

This block is the arithmetic slice of a small load/store processor core. The second operand is taken either from a register value or from an immediate constant. It first passes through a barrel shifter that can shift left, shift right logically, shift right arithmetically, rotate right, or rotate right by one place through the stored carry. The shaped operand then meets the first operand in an adder or a bitwise logic unit. The outputs are a 32-bit result, a result write-enable and four condition flags: negative, zero, carry and overflow.

A registered flag holder keeps the current flags. It supplies the carry used by add-with-carry, subtract-with-carry, the unshifted case and the one-place rotate. It also supplies the overflow value that logical operations leave unchanged. Four comparison and test operations only update the flags and never ask for a result write. The shifter, the execution unit and the holder are separate modules. The datapath itself is combinational, so a result and its flags are ready in the same cycle as the inputs, and the flags are stored on the next rising clock edge.

The block has no sequencing of its own. Its only state is the flag holder. The holder has two transitions: it loads new flags when the flag write is active, and it holds its value otherwise.

Top module: `shift_alu`

## Requirements
- R1: Opcode 6 (add) adds A to the shaped operand. 0xFFFFFFFF + 0x00000001 gives result 0 with flags_next = 4'b0110. 0x7FFFFFFF + 0x00000001 gives 0x80000000 with flags_next = 4'b1001. flags_next is ordered {N, Z, C, V}.
- R2: Each arithmetic opcode sets C to the adder carry-out and V to signed overflow.
  - 7 (add with carry) computes A + B + C.
  - 8 (subtract) computes A − B, with C = 1 exactly when no borrow occurs.
  - 9 (subtract with carry) computes A − B − (1 − C).
  - 10 (reverse subtract) computes B − A.
  - 11 (reverse subtract with carry) computes B − A − (1 − C).
  - In every case, C is the stored carry flag and B is the shaped operand.
- R3: The logical opcodes are:
  - 0: A AND B
  - 1: A OR B
  - 2: A XOR B
  - 3: A AND NOT B
  - 4: move B
  - 5: move NOT B

  For these, C takes the shifter carry-out and V keeps its stored value. N is always result bit 31, and Z is set when the result is zero.
- R4: Shift kind 0 shifts left by the amount and kind 1 shifts right logically. Both fill vacated positions with zeros, and the shifter carry is the last bit shifted out.
- R5: Shift kind 2 shifts right arithmetically. Vacated positions take the sign bit, and the carry is the last bit shifted out.
- R6: Shift kind 3 rotates right by the amount, and the carry is the bit that lands in position 31.
- R7: Shift kind 4 rotates right by one place through the carry, whatever the shift amount. The shaped operand is {C, B[31:1]} and the shifter carry is B[0].
- R8: A shift amount of 0 with kinds 0–3, and any amount with kinds 5–7, passes B through unchanged. The shifter carry then equals the stored C.
- R9: Opcodes 12 (AND test), 13 (XOR test), 14 (subtract compare) and 15 (add compare) drive result_we low. They still update the stored flags even when set_flags is low.
- R10: The stored flags reset to zero. They load flags_next on a clock edge only when set_flags is high or a test opcode is applied, and hold otherwise. status_word carries them in bits 31:28 as N, Z, C, V, with all other bits zero.
- R11: When b_from_imm is high the immediate input is the operand fed to the shifter; otherwise the register input is used. For all other opcodes result_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag holder |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a | input | 32 | First operand |
| opnd_b_reg | input | 32 | Second operand, register source |
| opnd_b_imm | input | 32 | Second operand, immediate source |
| b_from_imm | input | 1 | Select immediate as second operand |
| op_code | input | 4 | Operation code (see R1–R3, R9) |
| shift_kind | input | 3 | Shifter mode (see R4–R8) |
| shift_amt | input | 5 | Shift or rotate distance |
| set_flags | input | 1 | Request that flags be stored |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_next | output | 4 | Flags produced this cycle, {N,Z,C,V} |
| status_word | output | 32 | Stored flags in bits 31:28 |

## Verification
Directed cases cover the following:
- the two named addition corners, which separate the carry flag from the overflow flag;
- each shifter mode on operands whose top and bottom bits differ, which shows whether zero fill is mistaken for sign fill and whether the carry is taken from the wrong end;
- a rotate through a known stored carry;
- a zero shift amount after the carry has been set;
- a compare issued with set_flags low;
- an unflagged add, which must leave the stored word untouched.

Seeded random operands, opcodes, shift kinds and amounts are then mixed with all-ones, zero and sign-boundary values. This exercises borrow and overflow in every subtract variant and the carry chained in through the stored flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND     = 4'd0,
        OP_OR      = 4'd1,
        OP_XOR     = 4'd2,
        OP_ANDNOT  = 4'd3,
        OP_MOVE    = 4'd4,
        OP_MOVENOT = 4'd5,
        OP_ADD     = 4'd6,
        OP_ADDC    = 4'd7,
        OP_SUB     = 4'd8,
        OP_SUBC    = 4'd9,
        OP_RSUB    = 4'd10,
        OP_RSUBC   = 4'd11,
        OP_TESTAND = 4'd12,
        OP_TESTXOR = 4'd13,
        OP_CMPSUB  = 4'd14,
        OP_CMPADD  = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } sh_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic op_is_test(alu_op_e op);
        return (op == OP_TESTAND) || (op == OP_TESTXOR) ||
               (op == OP_CMPSUB)  || (op == OP_CMPADD);
    endfunction

    function automatic logic op_is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_ANDNOT) || (op == OP_MOVE) || (op == OP_MOVENOT) ||
               (op == OP_TESTAND) || (op == OP_TESTXOR);
    endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  sh_kind_e      kind,
    input  logic [AW-1:0] amt,
    input  logic          cin,
    output logic [W-1:0]  dout,
    output logic          cout
);

    logic [AW-1:0] idx_lo;
    logic [AW-1:0] idx_hi;

    always_comb begin
        idx_lo = amt - AW'(1);
        idx_hi = AW'(W) - amt;
        dout   = din;
        cout   = cin;
        if (kind == SH_RRX) begin
            dout = {cin, din[W-1:1]};
            cout = din[0];
        end else if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    dout = din << amt;
                    cout = din[idx_hi];
                end
                SH_LSR: begin
                    dout = din >> amt;
                    cout = din[idx_lo];
                end
                SH_ASR: begin
                    dout = $signed(din) >>> amt;
                    cout = din[idx_lo];
                end
                SH_ROR: begin
                    dout = (din >> amt) | (din << idx_hi);
                    cout = din[idx_lo];
                end
                default: begin
                    dout = din;
                    cout = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] sb,
    input  alu_op_e      op,
    input  logic         c_in,
    input  logic         v_in,
    input  logic         sh_c,
    output logic [W-1:0] res,
    output flags_t       fl
);

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         ci;
    logic         arith;
    logic [W:0]   sum;
    logic [W-1:0] lres;

    always_comb begin
        x     = a;
        y     = sb;
        ci    = 1'b0;
        arith = 1'b1;
        unique case (op)
            OP_ADD, OP_CMPADD: ci = 1'b0;
            OP_ADDC:           ci = c_in;
            OP_SUB, OP_CMPSUB: begin y = ~sb; ci = 1'b1; end
            OP_SUBC:           begin y = ~sb; ci = c_in; end
            OP_RSUB:           begin x = sb; y = ~a; ci = 1'b1; end
            OP_RSUBC:          begin x = sb; y = ~a; ci = c_in; end
            default:           arith = 1'b0;
        endcase
        sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    end

    always_comb begin
        unique case (op)
            OP_AND, OP_TESTAND: lres = a & sb;
            OP_OR:              lres = a | sb;
            OP_XOR, OP_TESTXOR: lres = a ^ sb;
            OP_ANDNOT:          lres = a & ~sb;
            OP_MOVE:            lres = sb;
            OP_MOVENOT:         lres = ~sb;
            default:            lres = '0;
        endcase
    end

    always_comb begin
        res  = arith ? sum[W-1:0] : lres;
        fl.n = res[W-1];
        fl.z = (res == '0);
        fl.c = arith ? sum[W] : sh_c;
        fl.v = arith ? ((x[W-1] == y[W-1]) && (res[W-1] != x[W-1])) : v_in;
    end

endmodule

// File: rtl/alu_flag_hold.sv
module alu_flag_hold
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  flags_t       d,
    output flags_t       q,
    output logic [W-1:0] status_word
);

    localparam int LOW_BITS = W - 4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    assign status_word = {q, {LOW_BITS{1'b0}}};

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));

endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import alu_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b_reg,
    input  logic [W-1:0]  opnd_b_imm,
    input  logic          b_from_imm,
    input  logic [3:0]    op_code,
    input  logic [2:0]    shift_kind,
    input  logic [AW-1:0] shift_amt,
    input  logic          set_flags,
    output logic [W-1:0]  result,
    output logic          result_we,
    output logic [3:0]    flags_next,
    output logic [W-1:0]  status_word
);

    alu_op_e      op;
    sh_kind_e     kind;
    logic [W-1:0] b_sel;
    logic [W-1:0] b_shaped;
    logic         sh_carry;
    flags_t       fl_now;
    flags_t       fl_q;
    logic         flag_we;

    assign op    = alu_op_e'(op_code);
    assign kind  = sh_kind_e'(shift_kind);
    assign b_sel = b_from_imm ? opnd_b_imm : opnd_b_reg;

    alu_shifter #(.W(W)) u_shift (
        .din  (b_sel),
        .kind (kind),
        .amt  (shift_amt),
        .cin  (fl_q.c),
        .dout (b_shaped),
        .cout (sh_carry)
    );

    alu_exec #(.W(W)) u_exec (
        .a    (opnd_a),
        .sb   (b_shaped),
        .op   (op),
        .c_in (fl_q.c),
        .v_in (fl_q.v),
        .sh_c (sh_carry),
        .res  (result),
        .fl   (fl_now)
    );

    assign flag_we    = set_flags | op_is_test(op);
    assign result_we  = ~op_is_test(op);
    assign flags_next = fl_now;

    alu_flag_hold #(.W(W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (flag_we),
        .d           (fl_now),
        .q           (fl_q),
        .status_word (status_word)
    );

    assert_test_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 4'd12) |-> !result_we);

    assert_logic_keeps_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_logic(op) |-> (flags_next[0] == status_word[W-4]));

    assert_rrx_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((shift_kind == 3'd4) && (op_code == 4'd4)) |-> (flags_next[1] == b_sel[0]));

    assert_test_stores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 4'd12) |=> (status_word[W-1:W-4] == $past(flags_next)));

endmodule

// File: tb/sim_shift_alu.sv
`timescale 1ns/1ps
module sim_shift_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b_reg = '0;
    logic [31:0] opnd_b_imm = '0;
    logic        b_from_imm = 1'b0;
    logic [3:0]  op_code = '0;
    logic [2:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_next;
    logic [31:0] status_word;

    int n_checks = 0;
    int n_fail = 0;
    logic [3:0] exp_st = 4'b0000;

    always #4 clk = ~clk;

    shift_alu u0 (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b_reg(opnd_b_reg),
        .opnd_b_imm(opnd_b_imm), .b_from_imm(b_from_imm), .op_code(op_code),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .set_flags(set_flags),
        .result(result), .result_we(result_we), .flags_next(flags_next),
        .status_word(status_word)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] shape(logic [31:0] b, logic [2:0] kind,
                                          logic [4:0] amt, logic c);
        logic [31:0] s = b;
        logic sc = c;
        if (kind == 3'd4) begin
            sc = b[0];
            s = {c, b[31:1]};
        end else begin
            for (int i = 0; i < int'(amt); i++) begin
                case (kind)
                    3'd0: begin sc = s[31]; s = {s[30:0], 1'b0}; end
                    3'd1: begin sc = s[0]; s = {1'b0, s[31:1]}; end
                    3'd2: begin sc = s[0]; s = {s[31], s[31:1]}; end
                    3'd3: begin sc = s[0]; s = {s[0], s[31:1]}; end
                    default: ;
                endcase
            end
        end
        return {sc, s};
    endfunction

    function automatic logic [35:0] model(logic [31:0] a, logic [31:0] b,
                                          logic [3:0] op, logic [2:0] kind,
                                          logic [4:0] amt, logic c, logic v);
        logic [32:0] sh = shape(b, kind, amt, c);
        logic [31:0] s = sh[31:0];
        logic [31:0] r = '0;
        logic nc = sh[32];
        logic nv = v;
        longint ua = longint'(a);
        longint us = longint'(s);
        longint sa = longint'($signed(a));
        longint ss = longint'($signed(s));
        longint bor = (c == 1'b1) ? 64'sd0 : 64'sd1;
        longint sr = 0;
        bit arith = 1'b1;
        case (op)
            4'd6, 4'd15: begin r = a + s; nc = (ua + us) > 64'sh0FFFFFFFF; sr = sa + ss; end
            4'd7: begin r = a + s + {31'd0, c}; nc = (ua + us + longint'(c)) > 64'sh0FFFFFFFF;
                        sr = sa + ss + longint'(c); end
            4'd8, 4'd14: begin r = a - s; nc = ua >= us; sr = sa - ss; end
            4'd9: begin r = a - s - 32'(bor); nc = ua >= us + bor; sr = sa - ss - bor; end
            4'd10: begin r = s - a; nc = us >= ua; sr = ss - sa; end
            4'd11: begin r = s - a - 32'(bor); nc = us >= ua + bor; sr = ss - sa - bor; end
            default: arith = 1'b0;
        endcase
        if (arith) nv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        case (op)
            4'd0, 4'd12: r = a & s;
            4'd1: r = a | s;
            4'd2, 4'd13: r = a ^ s;
            4'd3: r = a & ~s;
            4'd4: r = s;
            4'd5: r = ~s;
            default: ;
        endcase
        return {r[31], (r == 32'd0), nc, nv, r};
    endfunction

    task automatic step(string tag, logic [31:0] a, logic [31:0] br, logic [31:0] bi,
                        logic isimm, logic [3:0] op, logic [2:0] kind,
                        logic [4:0] amt, logic sf);
        logic [35:0] m;
        logic tst;
        @(negedge clk);
        opnd_a = a; opnd_b_reg = br; opnd_b_imm = bi; b_from_imm = isimm;
        op_code = op; shift_kind = kind; shift_amt = amt; set_flags = sf;
        #1;
        m = model(a, isimm ? bi : br, op, kind, amt, exp_st[1], exp_st[0]);
        tst = (op >= 4'd12);
        if (!tst) check({tag, " result"}, result, m[31:0]);
        check({tag, " R11 write enable"}, {31'd0, result_we}, {31'd0, !tst});
        check({tag, " flags"}, {28'd0, flags_next}, {28'd0, m[35:32]});
        if (sf || tst) exp_st = m[35:32];
        @(posedge clk);
        #1;
        check({tag, " R10 stored"}, status_word, {exp_st, 28'd0});
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        #1;
        check("R10 reset status", status_word, 32'd0);
        rst_n = 1'b1;

        step("R1 minus1 plus1", 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0, 4'd6, 3'd0, 5'd0, 1'b1);
        check("R1 literal", {28'd0, exp_st}, {28'd0, 4'b0110});
        step("R1 max plus1", 32'h7FFFFFFF, 32'd1, 32'd0, 1'b0, 4'd6, 3'd0, 5'd0, 1'b1);
        check("R1 literal", {28'd0, exp_st}, {28'd0, 4'b1001});
        step("R4 left", 32'd0, 32'hF000000F, 32'd0, 1'b0, 4'd4, 3'd0, 5'd4, 1'b1);
        check("R4 literal", {28'd0, exp_st}, {28'd0, 4'b0011});
        step("R4 right", 32'd0, 32'h80000001, 32'd0, 1'b0, 4'd4, 3'd1, 5'd1, 1'b1);
        step("R5 arith", 32'd0, 32'h80000000, 32'd0, 1'b0, 4'd4, 3'd2, 5'd4, 1'b1);
        check("R5 literal", {28'd0, exp_st}, {28'd0, 4'b1001});
        step("R6 rotate", 32'd0, 32'h12345678, 32'd0, 1'b0, 4'd4, 3'd3, 5'd8, 1'b1);
        step("R2 set carry", 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0, 4'd6, 3'd0, 5'd0, 1'b1);
        step("R7 extended", 32'd0, 32'h00000003, 32'd0, 1'b0, 4'd4, 3'd4, 5'd9, 1'b1);
        check("R7 literal", {28'd0, exp_st}, {28'd0, 4'b1010});
        step("R7 extended again", 32'd0, 32'h00000002, 32'd0, 1'b0, 4'd4, 3'd4, 5'd0, 1'b1);
        step("R2 set carry", 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0, 4'd6, 3'd0, 5'd0, 1'b1);
        step("R8 zero amount", 32'd0, 32'h5, 32'd0, 1'b0, 4'd4, 3'd0, 5'd0, 1'b1);
        check("R8 carry kept", {31'd0, exp_st[1]}, 32'd1);
        step("R8 unused kind", 32'd0, 32'h5, 32'd0, 1'b0, 4'd1, 3'd6, 5'd7, 1'b1);
        step("R9 compare", 32'd5, 32'd5, 32'd0, 1'b0, 4'd14, 3'd0, 5'd0, 1'b0);
        step("R9 test and", 32'h0F, 32'hF0, 32'd0, 1'b0, 4'd12, 3'd0, 5'd0, 1'b0);
        step("R10 no store", 32'h7FFFFFFF, 32'd1, 32'd0, 1'b0, 4'd6, 3'd0, 5'd0, 1'b0);
        step("R11 immediate", 32'd10, 32'd99, 32'd3, 1'b1, 4'd8, 3'd0, 5'd0, 1'b1);
        step("R2 borrow", 32'd3, 32'd10, 32'd0, 1'b0, 4'd8, 3'd0, 5'd0, 1'b1);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb, ri;
            logic [3:0]  rop;
            string t;
            ra = $urandom; rb = $urandom; ri = $urandom;
            case ($urandom_range(0, 5))
                0: ra = 32'hFFFFFFFF;
                1: rb = 32'h80000000;
                2: ra = 32'h7FFFFFFF;
                3: rb = 32'd0;
                default: ;
            endcase
            rop = 4'($urandom_range(0, 15));
            if (rop >= 4'd12) t = "R9 random";
            else if (rop >= 4'd6) t = "R2 random";
            else t = "R3 random";
            step(t, ra, rb, ri, 1'($urandom_range(0, 1)), rop,
                 3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)),
                 1'($urandom_range(0, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule